// File: doc/BRIEF.md
# Thermal Shutdown Retry Controller

This block makes the on/off decision for one protected power-switch channel. It reads an enable request and a current-limit-active flag. It also reads two unsigned temperature codes, one from the power transistor and one from the controller die. From these it drives the channel gate enable and an active-low fault flag.

The channel shuts down on either of two thermal criteria:
- a relative criterion, when the transistor runs too far above the controller;
- an absolute criterion, when the transistor reaches a fixed limit.

A run-time mode input chooses how the channel recovers. In auto-retry mode a retry timer brings the channel back. An absolute trip also needs the transistor to cool below a hysteresis floor. In latch mode the channel stays off until software drops the enable request and raises it again.

The thresholds arrive as input codes, so firmware can tune them. The retry delay is a build-time cycle count.

Top module: `thermal_retry_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_on` is 0 and `fault_n` is 1 (fault not asserted; `fault_n` low means asserted).
- R2: With no trip and `en_req` high, `gate_on` is 1 one cycle after the edge that samples it. With `en_req` low, `gate_on` is 0 one cycle after the edge that samples it.
- R3: While the channel is on and enabled, `ilim_active` high drives `fault_n` low one cycle later. When `ilim_active` falls (and no trip occurs), `fault_n` returns high one cycle later.
- R4: A relative trip occurs when `t_fet - t_ctl` is strictly greater than `t_rel_th`. The difference is taken as zero when `t_ctl >= t_fet`. A difference equal to the threshold does not trip.
- R5: An absolute trip occurs when `t_fet >= t_abs_lim`. When both criteria hold in the same cycle, the absolute trip wins and its recovery rule applies.
- R6: In auto-retry mode (`latch_mode` = 0), after a relative trip the gate stays off for exactly `RETRY_CYCLES` cycles and then turns on again, provided enable is still high.
- R7: In auto-retry mode, after an absolute trip the gate turns on only at the end of a retry period in which `t_fet < t_abs_lim - t_hys`. If the transistor is still hot at the end of a period, the controller waits for a later period end.
- R8: In latch mode (`latch_mode` = 1), after either trip the gate stays off for as long as `en_req` stays high. Enable must go low and then high again before the gate turns on.
- R9: `fault_n` stays low for the whole time the channel is held off by a trip, in both modes.
- R10: `en_req` low during any shutdown returns the channel to off with `fault_n` high one cycle later. It also resets the retry timer, so the next trip waits a full `RETRY_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Channel enable request |
| latch_mode | input | 1 | 1 = latch recovery, 0 = auto-retry recovery |
| ilim_active | input | 1 | Current limiter is regulating |
| t_fet | input | TEMP_W | Power transistor temperature code |
| t_ctl | input | TEMP_W | Controller temperature code |
| t_rel_th | input | TEMP_W | Relative rise threshold |
| t_abs_lim | input | TEMP_W | Absolute temperature limit |
| t_hys | input | TEMP_W | Cool-down hysteresis below the absolute limit |
| gate_on | output | 1 | Channel gate enable |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The assertions check these rules on every cycle:
- enable low forces the gate off and clears the fault flag;
- a current limit during conduction asserts the fault flag;
- an absolute trip during conduction removes the gate;
- a latched channel stays off with the fault flag asserted while enable is held high.

Only the bench's scenarios can show the following:
- the exact length of the retry window;
- absolute priority over a simultaneous relative trip, which is visible only through the cool-down rule at period end;
- the strict-versus-equal boundary and the zero floor of the relative comparison;
- that an enable toggle restarts the timer from zero.

// File: rtl/thermal_retry_pkg.sv
package thermal_retry_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_ON      = 3'd1,
    ST_REL_SD  = 3'd2,
    ST_ABS_SD  = 3'd3,
    ST_LATCHED = 3'd4
  } chan_state_e;

endpackage

// File: rtl/thermal_trip_eval.sv
module thermal_trip_eval #(
  parameter int TW = 10
) (
  input  logic [TW-1:0] t_fet,
  input  logic [TW-1:0] t_ctl,
  input  logic [TW-1:0] t_rel_th,
  input  logic [TW-1:0] t_abs_lim,
  input  logic [TW-1:0] t_hys,
  output logic          rel_trip,
  output logic          abs_trip,
  output logic          abs_cool
);

  logic [TW-1:0] rise;
  logic [TW-1:0] cool_floor;

  // Rise of the transistor over the controller, floored at zero.
  always_comb begin
    if (t_fet > t_ctl) rise = t_fet - t_ctl;
    else               rise = '0;
  end

  // Floor below which an absolute trip may clear, floored at zero.
  always_comb begin
    if (t_abs_lim > t_hys) cool_floor = t_abs_lim - t_hys;
    else                   cool_floor = '0;
  end

  assign rel_trip = (rise > t_rel_th);
  assign abs_trip = (t_fet >= t_abs_lim);
  assign abs_cool = (t_fet < cool_floor);

endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Counting is enabled in shutdown, and clearing whenever counting stops.
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/thermal_retry_fsm.sv
module thermal_retry_fsm
  import thermal_retry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic latch_mode,
  input  logic ilim_active,
  input  logic rel_trip,
  input  logic abs_trip,
  input  logic abs_cool,
  input  logic retry_expire,
  output logic timer_run,
  output logic latched,
  output logic gate_on,
  output logic fault_n
);

  chan_state_e state_q, state_d;
  logic        gate_d;
  logic        fault_d;
  logic        any_trip;
  chan_state_e trip_dest;

  assign any_trip = abs_trip || rel_trip;

  // Destination on a trip: the mode picks latching, and abs beats rel.
  always_comb begin
    if (latch_mode)    trip_dest = ST_LATCHED;
    else if (abs_trip) trip_dest = ST_ABS_SD;
    else               trip_dest = ST_REL_SD;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (en_req) state_d = ST_ON;
      end
      ST_ON: begin
        if (!en_req)       state_d = ST_OFF;
        else if (any_trip) state_d = trip_dest;
      end
      ST_REL_SD: begin
        if (!en_req)           state_d = ST_OFF;
        else if (retry_expire) state_d = ST_ON;
      end
      ST_ABS_SD: begin
        if (!en_req)                       state_d = ST_OFF;
        else if (retry_expire && abs_cool) state_d = ST_ON;
      end
      ST_LATCHED: begin
        if (!en_req) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_comb begin
    gate_d  = (state_d == ST_ON);
    fault_d = ((state_d == ST_ON) && ilim_active) ||
              (state_d == ST_REL_SD) || (state_d == ST_ABS_SD) ||
              (state_d == ST_LATCHED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      gate_on <= 1'b0;
      fault_n <= 1'b1;
    end else begin
      state_q <= state_d;
      gate_on <= gate_d;
      fault_n <= !fault_d;
    end
  end

  assign timer_run = (state_q == ST_REL_SD) || (state_q == ST_ABS_SD);
  assign latched   = (state_q == ST_LATCHED);

endmodule

// File: rtl/thermal_retry_ctrl.sv
module thermal_retry_ctrl #(
  parameter int TEMP_W       = 10,
  parameter int RETRY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              latch_mode,
  input  logic              ilim_active,
  input  logic [TEMP_W-1:0] t_fet,
  input  logic [TEMP_W-1:0] t_ctl,
  input  logic [TEMP_W-1:0] t_rel_th,
  input  logic [TEMP_W-1:0] t_abs_lim,
  input  logic [TEMP_W-1:0] t_hys,
  output logic              gate_on,
  output logic              fault_n
);

  logic rel_trip;
  logic abs_trip;
  logic abs_cool;
  logic timer_run;
  logic retry_expire;
  logic latched;

  thermal_trip_eval #(.TW(TEMP_W)) u_eval (
    .t_fet     (t_fet),
    .t_ctl     (t_ctl),
    .t_rel_th  (t_rel_th),
    .t_abs_lim (t_abs_lim),
    .t_hys     (t_hys),
    .rel_trip  (rel_trip),
    .abs_trip  (abs_trip),
    .abs_cool  (abs_cool)
  );

  retry_timer #(.CYCLES(RETRY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .expire (retry_expire)
  );

  thermal_retry_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_req       (en_req),
    .latch_mode   (latch_mode),
    .ilim_active  (ilim_active),
    .rel_trip     (rel_trip),
    .abs_trip     (abs_trip),
    .abs_cool     (abs_cool),
    .retry_expire (retry_expire),
    .timer_run    (timer_run),
    .latched      (latched),
    .gate_on      (gate_on),
    .fault_n      (fault_n)
  );

endmodule

// File: rtl/thermal_retry_chk.sv
module thermal_retry_chk #(
  parameter int TW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_req,
  input logic          ilim_active,
  input logic [TW-1:0] t_fet,
  input logic [TW-1:0] t_abs_lim,
  input logic          latched,
  input logic          gate_on,
  input logic          fault_n
);

  // R2
  en_low_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !gate_on);

  // R10
  en_low_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> fault_n);

  // R2
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(en_req));

  // R3
  ilim_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on && en_req && ilim_active |=> !fault_n);

  // R5
  abs_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on && en_req && (t_fet >= t_abs_lim) |=> !gate_on && !fault_n);

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched && en_req |=> !gate_on && !fault_n);

endmodule

bind thermal_retry_ctrl thermal_retry_chk #(.TW(TEMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_req      (en_req),
  .ilim_active (ilim_active),
  .t_fet       (t_fet),
  .t_abs_lim   (t_abs_lim),
  .latched     (latched),
  .gate_on     (gate_on),
  .fault_n     (fault_n)
);

// File: tb/test_thermal_retry_ctrl.sv
module test_thermal_retry_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam int RC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_req = 1'b0;
  logic          latch_mode = 1'b0;
  logic          ilim_active = 1'b0;
  logic [TW-1:0] t_fet = '0;
  logic [TW-1:0] t_ctl = '0;
  logic [TW-1:0] t_rel_th = '0;
  logic [TW-1:0] t_abs_lim = '0;
  logic [TW-1:0] t_hys = '0;
  logic          gate_on;
  logic          fault_n;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_retry_ctrl #(.TEMP_W(TW), .RETRY_CYCLES(RC)) i_thermal_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .latch_mode(latch_mode),
    .ilim_active(ilim_active), .t_fet(t_fet), .t_ctl(t_ctl),
    .t_rel_th(t_rel_th), .t_abs_lim(t_abs_lim), .t_hys(t_hys),
    .gate_on(gate_on), .fault_n(fault_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cool_temps();
    t_fet = 10'd300; t_ctl = 10'd280;
  endtask

  task automatic go_idle();
    en_req = 1'b0; ilim_active = 1'b0; latch_mode = 1'b0;
    cool_temps();
    step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en_req = 1'b1;
    step(3);
    check("R1 gate in reset", gate_on, 1'b0);
    check("R1 fault_n in reset", fault_n, 1'b1);
    en_req = 1'b0;
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_enable();
    go_idle();
    en_req = 1'b1; step(1);
    check("R2 gate on after enable", gate_on, 1'b1);
    check("R2 no fault when on", fault_n, 1'b1);
    en_req = 1'b0; step(1);
    check("R2 gate off after disable", gate_on, 1'b0);
  endtask

  task automatic t_ilim();
    go_idle();
    en_req = 1'b1; step(1);
    ilim_active = 1'b1; step(1);
    check("R3 fault on limit", fault_n, 1'b0);
    check("R3 gate stays on in limit", gate_on, 1'b1);
    ilim_active = 1'b0; step(1);
    check("R3 fault clears", fault_n, 1'b1);
  endtask

  task automatic t_rel_bounds();
    go_idle();
    en_req = 1'b1; step(1);
    t_fet = 10'd400; t_ctl = 10'd300; step(3);
    check("R4 equal rise no trip", gate_on, 1'b1);
    t_rel_th = 10'd0; t_fet = 10'd100; t_ctl = 10'd900; step(3);
    check("R4 controller hotter no trip", gate_on, 1'b1);
    t_rel_th = 10'd100;
  endtask

  task automatic t_rel_retry();
    go_idle();
    en_req = 1'b1; step(1);
    t_fet = 10'd500; t_ctl = 10'd300; step(1);
    check("R4 rel trip gate", gate_on, 1'b0);
    check("R9 fault in rel sd", fault_n, 1'b0);
    cool_temps();
    step(RC-1);
    check("R6 still off before expiry", gate_on, 1'b0);
    check("R9 fault held", fault_n, 1'b0);
    step(1);
    check("R6 on after retry", gate_on, 1'b1);
    check("R6 fault clear after retry", fault_n, 1'b1);
  endtask

  task automatic t_abs_retry();
    go_idle();
    en_req = 1'b1; step(1);
    t_fet = 10'd800; t_ctl = 10'd0; step(1);
    check("R5 abs trip gate", gate_on, 1'b0);
    t_fet = 10'd760;
    step(RC);
    check("R5 priority, still hot at expiry", gate_on, 1'b0);
    check("R9 fault in abs sd", fault_n, 1'b0);
    t_fet = 10'd700; t_ctl = 10'd650;
    step(RC-1);
    check("R7 waits for period end", gate_on, 1'b0);
    step(1);
    check("R7 on after cool period", gate_on, 1'b1);
  endtask

  task automatic t_latch();
    go_idle();
    latch_mode = 1'b1;
    en_req = 1'b1; step(1);
    t_fet = 10'd500; t_ctl = 10'd300; step(1);
    check("R8 latched off", gate_on, 1'b0);
    cool_temps();
    step(RC + 5);
    check("R8 stays off past retry", gate_on, 1'b0);
    check("R9 fault while latched", fault_n, 1'b0);
    en_req = 1'b0; step(1);
    check("R10 fault clears on disable", fault_n, 1'b1);
    en_req = 1'b1; step(1);
    check("R8 on after toggle", gate_on, 1'b1);
  endtask

  task automatic t_abort();
    go_idle();
    en_req = 1'b1; step(1);
    t_fet = 10'd500; t_ctl = 10'd300; step(4);
    cool_temps();
    en_req = 1'b0; step(1);
    check("R10 gate off on disable", gate_on, 1'b0);
    check("R10 fault clear on disable", fault_n, 1'b1);
    en_req = 1'b1; step(1);
    check("R10 back on", gate_on, 1'b1);
    t_fet = 10'd500; t_ctl = 10'd300; step(1);
    cool_temps();
    step(RC-1);
    check("R10 fresh full count", gate_on, 1'b0);
    step(1);
    check("R10 on after full count", gate_on, 1'b1);
  endtask

  initial begin
    t_rel_th = 10'd100; t_abs_lim = 10'd800; t_hys = 10'd50;
    cool_temps();
    step(1);
    t_reset();
    t_enable();
    t_ilim();
    t_rel_bounds();
    t_rel_retry();
    t_abs_retry();
    t_latch();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule